// File: doc/BRIEF.md
# Isolated S-box Lookup Address Unit

This block serves block-cipher substitution-table lookups from a small private scratch memory. Secret-derived table indices therefore never travel through a cached memory hierarchy. A 32-bit staging word is taken from the top of a 128-bit cipher register. In the same cycle the unit hands back that register shifted up by one word, with the vacated low word filled with zeros. Each lookup command does four things:

- It adds the staging word's most significant byte to a caller-supplied base address.
- It rotates the staging word left by one byte, so four consecutive lookups walk its bytes from most to least significant.
- It reads the scratch table at the resulting address.
- It places both the address and the table word in output registers meant for the general-purpose register file.

A clear command wipes the staging word and both output registers so that no secret-dependent residue remains.

The scratch table answers only inside a fixed window of `WIN_WORDS` consecutive word addresses starting at `WIN_BASE`. A lookup outside that window reads nothing: it returns zero and raises an error flag. A table write outside the window is dropped. The table is filled through a dedicated write port.

A three-state controller reports the outcome of the previous command:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | No lookup was accepted in the previous cycle. |
| `ST_RESULT` | An in-window lookup was accepted. |
| `ST_FAULT` | An out-of-window lookup was accepted. |

On every clock the controller moves as follows, whatever its current state:

| Command in the current cycle | Next state |
|------------------------------|------------|
| Lookup whose address is inside the window | `ST_RESULT` |
| Lookup whose address is outside the window | `ST_FAULT` |
| No valid command, or a no-op, load or clear | `ST_IDLE` |

Top module: `sbox_lookup_unit`

## Requirements
- R1: After reset, `sbox_word`, `cr_out`, `addr_out` and `data_out` are all zero, and `data_valid` and `lookup_err` are low.
- R2: A valid load command (`cmd_op` = 2'd1) makes `sbox_word` equal `cr_in[127:96]` and `cr_out` equal `{cr_in[95:0], 32'h0}` in the next cycle.
- R3: A valid lookup command (`cmd_op` = 2'd2) makes `addr_out` equal `base_addr + sbox_word[31:24]` in the next cycle. The byte is zero-extended and the sum wraps modulo 2^32.
- R4: A lookup rotates `sbox_word` left by 8 bits. Four successive lookups therefore use its bytes from most to least significant and restore the original word.
- R5: For a lookup whose address A satisfies `WIN_BASE <= A < WIN_BASE + WIN_WORDS`, `data_out` holds the table word at index `A - WIN_BASE` in the next cycle. In that cycle `data_valid` is high for exactly one cycle and `lookup_err` is low.
- R6: For a lookup whose address is outside the window, including addresses reached by wrap-around, the next cycle has `data_out` zero, `lookup_err` high for one cycle and `data_valid` low.
- R7: When `tbl_wr_en` is high, a table write lands only if `tbl_wr_addr` is inside the window. A write outside the window changes no table entry. Writes take effect for lookups in later cycles.
- R8: A valid clear command (`cmd_op` = 2'd3) zeroes `sbox_word`, `addr_out` and `data_out` in the next cycle and leaves `cr_out` unchanged.
- R9: In a cycle with `cmd_valid` low, or with a no-op command (`cmd_op` = 2'd0), `sbox_word`, `cr_out`, `addr_out` and `data_out` keep their values. In the following cycle `data_valid` and `lookup_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 no-op, 1 load, 2 lookup, 3 clear |
| cr_in | input | 128 | Cipher register value for a load |
| base_addr | input | 32 | Table base address for a lookup |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 32 | Table write address (window checked) |
| tbl_wr_data | input | 32 | Table write data |
| cr_out | output | 128 | Cipher register shifted left by one word after the last load |
| sbox_word | output | 32 | Staging word |
| addr_out | output | 32 | Address formed by the last lookup |
| data_out | output | 32 | Table word returned by the last lookup |
| data_valid | output | 1 | In-window lookup result present this cycle |
| lookup_err | output | 1 | Out-of-window lookup reported this cycle |

## Verification
Every result is due on the first clock edge after the command is sampled:

- the staging word and the shifted register after a load;
- the address, the rotated staging word and the table word after a lookup;
- the zeroed registers after a clear;
- the one-cycle `data_valid` or `lookup_err` pulse.

The bench drives each command half a period before an edge. Its behavioural reference model updates its expected values for that edge. All six outputs are compared a short time after the edge, so each result is checked in the single cycle it is first due. A table write is checked through a later lookup.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

    typedef enum logic [1:0] {
        OP_NOP    = 2'd0,
        OP_LOAD   = 2'd1,
        OP_LOOKUP = 2'd2,
        OP_CLEAR  = 2'd3
    } sbl_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_FAULT  = 2'd2
    } sbl_state_e;

    localparam int LANE_W = 8;

endpackage

// File: rtl/sbl_window.sv
module sbl_window #(
    parameter int              AW        = 32,
    parameter logic [AW-1:0]   WIN_BASE  = '0,
    parameter int              WIN_WORDS = 256,
    parameter int              IDXW      = 8
) (
    input  logic [AW-1:0]   addr,
    output logic            hit,
    output logic [IDXW-1:0] idx
);

    logic [AW-1:0] offs;

    always_comb begin
        offs = addr - WIN_BASE;
        hit  = (offs < AW'(WIN_WORDS));
        idx  = offs[IDXW-1:0];
    end

endmodule

// File: rtl/sbl_stage.sv
module sbl_stage
    import sbl_pkg::*;
#(
    parameter int CRW = 128,
    parameter int SW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           do_load,
    input  logic           do_rot,
    input  logic           do_clear,
    input  logic [CRW-1:0] cr_in,
    output logic [SW-1:0]  sbox_q,
    output logic [CRW-1:0] cr_q,
    output logic [LANE_W-1:0] top_lane
);

    localparam int NLANES = SW / LANE_W;

    logic [SW-1:0] rot_w;

    // rotate left by one lane: lane i takes lane i-1, lane 0 takes the top lane
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int SRC = (g + NLANES - 1) % NLANES;
        assign rot_w[g*LANE_W +: LANE_W] = sbox_q[SRC*LANE_W +: LANE_W];
    end

    assign top_lane = sbox_q[SW-1 -: LANE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sbox_q <= '0;
        end else if (do_clear) begin
            sbox_q <= '0;
        end else if (do_load) begin
            sbox_q <= cr_in[CRW-1 -: SW];
        end else if (do_rot) begin
            sbox_q <= rot_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr_q <= '0;
        end else if (do_load) begin
            cr_q <= {cr_in[CRW-SW-1:0], {SW{1'b0}}};
        end
    end

    // R4: rotation preserves the population of the staging word
    a_r4_rotate_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rot && !do_load && !do_clear) |=> ($countones(sbox_q) == $countones($past(sbox_q))));

    // R8: clear empties the staging word
    a_r8_clear_stage: assert property (@(posedge clk) disable iff (!rst_n)
        do_clear |=> (sbox_q == '0));

    // R2: shifted register has an empty low word
    a_r2_low_fill: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (cr_q[SW-1:0] == '0));

endmodule

// File: rtl/sbl_scratch.sv
module sbl_scratch #(
    parameter int DW    = 32,
    parameter int WORDS = 256,
    parameter int IDXW  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic            rd_hit,
    input  logic [IDXW-1:0] rd_idx,
    input  logic            clr,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   data_q
);

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (clr) begin
            data_q <= '0;
        end else if (rd_en) begin
            data_q <= rd_hit ? mem[rd_idx] : '0;
        end
    end

    // R6: a read outside the window yields zero
    a_r6_miss_returns_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_hit && !clr) |=> (data_q == '0));

    // R8: clear empties the read register
    a_r8_clear_data: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (data_q == '0));

endmodule

// File: rtl/sbl_ctrl.sv
module sbl_ctrl
    import sbl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       hit,
    output logic       do_load,
    output logic       do_look,
    output logic       do_clear,
    output logic       data_valid,
    output logic       lookup_err
);

    sbl_op_e    op;
    sbl_state_e state_q, state_d;

    assign op = sbl_op_e'(cmd_op);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = ST_IDLE;
        if (cmd_valid) begin
            unique case (op)
                OP_LOOKUP: state_d = hit ? ST_RESULT : ST_FAULT;
                OP_NOP:    state_d = ST_IDLE;
                OP_LOAD:   state_d = ST_IDLE;
                OP_CLEAR:  state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        do_load    = cmd_valid && (op == OP_LOAD);
        do_look    = cmd_valid && (op == OP_LOOKUP);
        do_clear   = cmd_valid && (op == OP_CLEAR);
        data_valid = 1'b0;
        lookup_err = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESULT: data_valid = 1'b1;
            ST_FAULT:  lookup_err = 1'b1;
            default:   ;
        endcase
    end

    // R5/R6: the two outcome flags never coincide
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_valid, lookup_err}));

    // R9: without a command the controller returns to idle
    a_r9_idle_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!data_valid && !lookup_err));

    // R5: a valid result only follows a lookup
    a_r5_valid_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op != 2'd2)) |=> !data_valid);

endmodule

// File: rtl/sbox_lookup_unit.sv
module sbox_lookup_unit
    import sbl_pkg::*;
#(
    parameter int            AW        = 32,
    parameter int            CRW       = 128,
    parameter int            SW        = 32,
    parameter int            DW        = 32,
    parameter logic [31:0]   WIN_BASE  = 32'h0000_1000,
    parameter int            WIN_WORDS = 256
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic [CRW-1:0] cr_in,
    input  logic [AW-1:0]  base_addr,
    input  logic           tbl_wr_en,
    input  logic [AW-1:0]  tbl_wr_addr,
    input  logic [DW-1:0]  tbl_wr_data,
    output logic [CRW-1:0] cr_out,
    output logic [SW-1:0]  sbox_word,
    output logic [AW-1:0]  addr_out,
    output logic [DW-1:0]  data_out,
    output logic           data_valid,
    output logic           lookup_err
);

    localparam int IDXW = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1;
    localparam logic [AW-1:0] WBASE = AW'(WIN_BASE);

    logic              do_load, do_look, do_clear;
    logic [LANE_W-1:0] top_lane;
    logic [AW-1:0]     eff_addr;
    logic              rd_hit, wr_hit;
    logic [IDXW-1:0]   rd_idx, wr_idx;
    logic [AW-1:0]     addr_q;

    assign eff_addr = base_addr + AW'(top_lane);

    sbl_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .hit        (rd_hit),
        .do_load    (do_load),
        .do_look    (do_look),
        .do_clear   (do_clear),
        .data_valid (data_valid),
        .lookup_err (lookup_err)
    );

    sbl_stage #(.CRW(CRW), .SW(SW)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_load  (do_load),
        .do_rot   (do_look),
        .do_clear (do_clear),
        .cr_in    (cr_in),
        .sbox_q   (sbox_word),
        .cr_q     (cr_out),
        .top_lane (top_lane)
    );

    sbl_window #(.AW(AW), .WIN_BASE(WBASE), .WIN_WORDS(WIN_WORDS), .IDXW(IDXW)) u_rd_win (
        .addr (eff_addr),
        .hit  (rd_hit),
        .idx  (rd_idx)
    );

    sbl_window #(.AW(AW), .WIN_BASE(WBASE), .WIN_WORDS(WIN_WORDS), .IDXW(IDXW)) u_wr_win (
        .addr (tbl_wr_addr),
        .hit  (wr_hit),
        .idx  (wr_idx)
    );

    sbl_scratch #(.DW(DW), .WORDS(WIN_WORDS), .IDXW(IDXW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (do_look),
        .rd_hit  (rd_hit),
        .rd_idx  (rd_idx),
        .clr     (do_clear),
        .wr_en   (tbl_wr_en && wr_hit),
        .wr_idx  (wr_idx),
        .wr_data (tbl_wr_data),
        .data_q  (data_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (do_clear) begin
            addr_q <= '0;
        end else if (do_look) begin
            addr_q <= eff_addr;
        end
    end

    assign addr_out = addr_q;

    // R3: the published address is the one formed in the lookup cycle
    a_r3_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
        do_look |=> (addr_out == $past(base_addr + AW'(sbox_word[SW-1 -: LANE_W]))));

    // R9: idle cycles leave the published registers untouched
    a_r9_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(addr_out) && $stable(data_out) && $stable(sbox_word) && $stable(cr_out)));

endmodule

// File: tb/sbox_lookup_unit_tb_top.sv
module sbox_lookup_unit_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] WBASE      = 32'h0000_1000;
    localparam int          WWORDS     = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = 2'd0;
    logic [127:0] cr_in = '0;
    logic [31:0]  base_addr = '0;
    logic         tbl_wr_en = 1'b0;
    logic [31:0]  tbl_wr_addr = '0;
    logic [31:0]  tbl_wr_data = '0;
    logic [127:0] cr_out;
    logic [31:0]  sbox_word, addr_out, data_out;
    logic         data_valid, lookup_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    logic [127:0] m_cr = '0;
    logic [31:0]  m_sbox = '0, m_addr = '0, m_data = '0;
    logic         m_valid = 0, m_err = 0;
    logic [31:0]  m_tbl [WWORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    sbox_lookup_unit #(.WIN_BASE(WBASE), .WIN_WORDS(WWORDS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cr_in(cr_in), .base_addr(base_addr), .tbl_wr_en(tbl_wr_en),
        .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
        .cr_out(cr_out), .sbox_word(sbox_word), .addr_out(addr_out),
        .data_out(data_out), .data_valid(data_valid), .lookup_err(lookup_err)
    );

    function automatic logic [31:0] tv(int i);
        return 32'hC0DE_0000 ^ (i * 32'h0001_0103);
    endfunction

    function automatic bit in_win(logic [31:0] a);
        logic [31:0] o;
        o = a - WBASE;
        return o < 32'(WWORDS);
    endfunction

    task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "sbox_word", 128'(sbox_word), 128'(m_sbox));
        chk(tag, "cr_out", cr_out, m_cr);
        chk(tag, "addr_out", 128'(addr_out), 128'(m_addr));
        chk(tag, "data_out", 128'(data_out), 128'(m_data));
        chk(tag, "data_valid", 128'(data_valid), 128'(m_valid));
        chk(tag, "lookup_err", 128'(lookup_err), 128'(m_err));
    endtask

    task automatic step(string tag, bit v, logic [1:0] op, logic [127:0] cr,
                        logic [31:0] base, bit we, logic [31:0] wa, logic [31:0] wd);
        logic [31:0] a;
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cr_in = cr; base_addr = base;
        tbl_wr_en = we; tbl_wr_addr = wa; tbl_wr_data = wd;
        m_valid = 0; m_err = 0;
        if (v) begin
            case (op)
                2'd1: begin
                    m_sbox = cr[127:96];
                    m_cr = {cr[95:0], 32'h0};
                end
                2'd2: begin
                    a = base + {24'h0, m_sbox[31:24]};
                    m_addr = a;
                    if (in_win(a)) begin
                        m_data = m_tbl[int'(a - WBASE)];
                        m_valid = 1;
                    end else begin
                        m_data = '0;
                        m_err = 1;
                    end
                    m_sbox = {m_sbox[23:0], m_sbox[31:24]};
                end
                2'd3: begin
                    m_sbox = '0; m_addr = '0; m_data = '0;
                end
                default: ;
            endcase
        end
        if (we && in_win(wa)) m_tbl[int'(wa - WBASE)] = wd;
        @(posedge clk);
        #2;
        compare_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WWORDS; i++) m_tbl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare_all("R1");

        // R7: fill the table through in-window writes
        for (int i = 0; i < WWORDS; i++)
            step("R7", 0, 2'd0, '0, '0, 1, WBASE + 32'(i), tv(i));
        // R7: writes just past either end of the window must be dropped
        step("R7", 0, 2'd0, '0, '0, 1, WBASE + 32'(WWORDS), 32'hDEAD_BEEF);
        step("R7", 0, 2'd0, '0, '0, 1, WBASE - 32'd1, 32'hBAD0_0001);

        // R2: chain of loads fed back from the shifted register
        step("R2", 1, 2'd1, 128'h01234567_89ABCDEF_FEDCBA98_76543210, '0, 0, '0, '0);
        for (int k = 0; k < 3; k++)
            step("R2", 1, 2'd1, m_cr, '0, 0, '0, '0);

        // R3 R4 R5: four lookups walk the bytes 00 FF 01 FE, restoring the word
        step("R2", 1, 2'd1, {32'h00FF_01FE, 96'h0}, '0, 0, '0, '0);
        for (int k = 0; k < 4; k++)
            step("R4", 1, 2'd2, '0, WBASE, 0, '0, '0);
        // R9: no-op keeps everything, flags drop
        step("R9", 1, 2'd0, '0, 32'h1234_5678, 0, '0, '0);
        step("R9", 0, 2'd2, '0, 32'h1234_5678, 0, '0, '0);
        step("R5", 1, 2'd2, '0, WBASE + 32'd16, 0, '0, '0);

        // R6: crossing the top of the window from a high base
        step("R2", 1, 2'd1, {32'h0F10_2030, 96'h5}, '0, 0, '0, '0);
        for (int k = 0; k < 4; k++)
            step("R6", 1, 2'd2, '0, WBASE + 32'h0000_00F0, 0, '0, '0);
        // R6: below the window and wrap-around
        step("R6", 1, 2'd2, '0, WBASE - 32'h100, 0, '0, '0);
        step("R6", 1, 2'd2, '0, 32'hFFFF_FFF0, 0, '0, '0);
        step("R5", 1, 2'd2, '0, WBASE, 0, '0, '0);

        // R8: clear, then idle and ignored load
        step("R8", 1, 2'd3, '0, '0, 0, '0, '0);
        step("R9", 0, 2'd1, {128{1'b1}}, '0, 0, '0, '0);
        step("R9", 1, 2'd0, '0, '0, 0, '0, '0);

        // R3: lookup after clear uses byte zero
        step("R3", 1, 2'd2, '0, WBASE + 32'd5, 0, '0, '0);

        // R7: rewrite an entry and read it back
        step("R7", 0, 2'd0, '0, '0, 1, WBASE + 32'd7, 32'h7777_0007);
        step("R7", 1, 2'd2, '0, WBASE + 32'd7, 0, '0, '0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule